// File: doc/BRIEF.md
# Maze-Walking Gem Collector Controller

This block is the decision core of a small maze-exploring robot. On every clock it reads four wall sensors, four light sensors (at most one lit at a time), a battery-low flag, a gem-under-robot flag and an overhead-hatch flag. It then commands exactly one move or none: step forward, turn clockwise, turn anticlockwise, pick up a gem, throw the carried gem out through a hatch, or jump out and power down. A backward-step command bit exists on the action bus but no state drives it.

While it explores, the controller hugs the left wall. When it must leave, because it carries a gem or the battery is low, it steers toward whatever light it sees. A hatch overhead ends the trip: with a low battery the robot jumps out and stays halted until reset, and with a gem in hand it throws the gem out and goes back to searching. The controller also holds one bit of state, whether a gem is being carried, and shows it on a status output. Outputs are decoded from the state register alone, which makes this a Moore machine.

Top module: `maze_walker`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `act_o` is all zero and `carrying_o` is 0. The next edge moves the controller into the search state.
- R2: `act_o` is one-hot or zero. Bit 0 is step forward, bit 1 step backward, bit 2 turn clockwise, bit 3 turn anticlockwise, bit 4 pick up, bit 5 throw out, bit 6 shut down. Bit 1 is never high.
- R3: In search, battery low together with a hatch leads to shutdown. This wins over every other condition, including a carried gem under a hatch.
- R4: In search, carrying a gem under a hatch (battery not low) leads to a single throw-out cycle (bit 5), then back to search.
- R5: An exit request is (battery low OR carrying) AND a light lit. It steers the robot by which light is lit: `light_i[0]` (left) gives a left turn, `light_i[1]` (ahead) a forward step, `light_i[2]` (right) a right turn, `light_i[3]` (behind) a turn-around. It ranks below R3 and R4 and above every other rule. Without an exit request the lights are ignored.
- R6: In search, when no gem is carried and `gem_here_i` is high (and no higher rule fires), the controller spends one pick-up cycle (bit 4). From the next cycle on, `carrying_o` is 1. A gem seen while carrying is ignored.
- R7: When no higher rule fires, left-wall following applies. `wall_i` uses the same bit order as the lights: bit 0 left, bit 1 ahead, bit 2 right, bit 3 behind. The first open side found, checked left, then ahead, then right, then behind, picks a left turn, a forward step, a right turn or a turn-around.
- R8: A left turn is one anticlockwise cycle (bit 3) and a right turn is one clockwise cycle (bit 2). Either one is followed by one forward-step cycle (bit 0), then search.
- R9: A turn-around is two consecutive clockwise cycles (bit 2), then search.
- R10: The cycle after a throw-out, `carrying_o` reads 0.
- R11: Once shutdown is entered, bit 6 stays high every cycle, whatever the inputs, until reset.
- R12: When no search rule fires (all walls present, no gem to take, no hatch or exit condition), the controller stays in search with `act_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| wall_i | input | 4 | Wall present: bit 0 left, 1 ahead, 2 right, 3 behind |
| light_i | input | 4 | Light seen, same bit order, at most one set |
| batt_low_i | input | 1 | Battery low |
| gem_here_i | input | 1 | Gem directly under the robot |
| hatch_i | input | 1 | Overhead hatch above the robot |
| act_o | output | 7 | One-hot action command (encoding in R2) |
| carrying_o | output | 1 | A gem is being carried |

## Verification
Sensors are read only in the search state. The edge that samples them loads the chosen state, and the matching action bit shows on `act_o` in the cycle right after that edge. Each step of a turn or turn-around then takes one more cycle per edge. The carried-gem flag changes one edge later than the action: it moves on the edge that leaves the pick-up or throw-out cycle, so it is seen two edges after the deciding search cycle. The bench drives the sensors a quarter period after a rising edge and advances its reference model on the next rising edge. It compares `act_o` and `carrying_o` a quarter period after that edge, so every comparison falls in the cycle in which its result is due.

// File: rtl/maze_walker_pkg.sv
package maze_walker_pkg;

  localparam int N_DIR = 4;
  localparam int N_ACT = 7;

  localparam int DIR_LEFT  = 0;
  localparam int DIR_AHEAD = 1;
  localparam int DIR_RIGHT = 2;
  localparam int DIR_BEHIND = 3;

  localparam int ACT_FWD   = 0;
  localparam int ACT_BACK  = 1;
  localparam int ACT_CW    = 2;
  localparam int ACT_CCW   = 3;
  localparam int ACT_PICK  = 4;
  localparam int ACT_THROW = 5;
  localparam int ACT_SHUT  = 6;

  typedef enum logic [3:0] {
    WS_INIT,
    WS_SEEK,
    WS_FWD,
    WS_TURN_L,
    WS_TURN_R,
    WS_SPIN_A,
    WS_SPIN_B,
    WS_GRAB,
    WS_EJECT,
    WS_JUMP,
    WS_HALT
  } walker_state_t;

  // Direction index to the state that faces or moves that way.
  function automatic walker_state_t dir_target(input int d);
    case (d)
      DIR_LEFT:  return WS_TURN_L;
      DIR_AHEAD: return WS_FWD;
      DIR_RIGHT: return WS_TURN_R;
      default:   return WS_SPIN_A;
    endcase
  endfunction

endpackage

// File: rtl/mw_seek_arbiter.sv
module mw_seek_arbiter
  import maze_walker_pkg::*;
(
  input  logic [N_DIR-1:0] wall_i,
  input  logic [N_DIR-1:0] light_i,
  input  logic             batt_low_i,
  input  logic             gem_here_i,
  input  logic             hatch_i,
  input  logic             carrying_i,
  output walker_state_t    seek_next_o
);

  logic          exit_req;
  logic          light_hit;
  logic          wall_gap;
  walker_state_t light_pick;
  walker_state_t wall_pick;

  assign exit_req  = (batt_low_i || carrying_i) && (|light_i);
  assign light_hit = exit_req;
  assign wall_gap  = ~(&wall_i);

  // Lowest direction index has precedence: scan from the top down.
  always_comb begin
    light_pick = WS_SEEK;
    for (int d = N_DIR - 1; d >= 0; d--) begin
      if (light_i[d]) light_pick = dir_target(d);
    end
  end

  always_comb begin
    wall_pick = WS_SEEK;
    for (int d = N_DIR - 1; d >= 0; d--) begin
      if (!wall_i[d]) wall_pick = dir_target(d);
    end
  end

  always_comb begin
    if (batt_low_i && hatch_i)         seek_next_o = WS_JUMP;
    else if (carrying_i && hatch_i)    seek_next_o = WS_EJECT;
    else if (light_hit)                seek_next_o = light_pick;
    else if (!carrying_i && gem_here_i) seek_next_o = WS_GRAB;
    else if (wall_gap)                 seek_next_o = wall_pick;
    else                               seek_next_o = WS_SEEK;
  end

endmodule

// File: rtl/mw_sequencer.sv
module mw_sequencer
  import maze_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DIR-1:0] wall_i,
  input  logic [N_DIR-1:0] light_i,
  input  logic             batt_low_i,
  input  logic             gem_here_i,
  input  logic             hatch_i,
  input  logic             carrying_i,
  output walker_state_t    state_o
);

  walker_state_t state_q;
  walker_state_t state_d;
  walker_state_t seek_next;

  mw_seek_arbiter u_arb (
    .wall_i      (wall_i),
    .light_i     (light_i),
    .batt_low_i  (batt_low_i),
    .gem_here_i  (gem_here_i),
    .hatch_i     (hatch_i),
    .carrying_i  (carrying_i),
    .seek_next_o (seek_next)
  );

  always_comb begin
    case (state_q)
      WS_INIT:   state_d = WS_SEEK;
      WS_SEEK:   state_d = seek_next;
      WS_FWD:    state_d = WS_SEEK;
      WS_TURN_L: state_d = WS_FWD;
      WS_TURN_R: state_d = WS_FWD;
      WS_SPIN_A: state_d = WS_SPIN_B;
      WS_SPIN_B: state_d = WS_SEEK;
      WS_GRAB:   state_d = WS_SEEK;
      WS_EJECT:  state_d = WS_SEEK;
      WS_JUMP:   state_d = WS_HALT;
      WS_HALT:   state_d = WS_HALT;
      default:   state_d = WS_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= WS_INIT;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R3
  jump_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SEEK && batt_low_i && hatch_i) |=> (state_q == WS_JUMP));

  // R11
  halt_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_HALT || state_q == WS_JUMP) |=> (state_q == WS_HALT));

  // R8
  turn_then_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_TURN_L || state_q == WS_TURN_R) |=> (state_q == WS_FWD));

  // R9
  spin_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SPIN_A) |=> (state_q == WS_SPIN_B));

  // R1
  init_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_INIT) |=> (state_q == WS_SEEK));

endmodule

// File: rtl/mw_carry_flag.sv
module mw_carry_flag
  import maze_walker_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  walker_state_t state_i,
  output logic          carrying_o
);

  logic carry_q;
  logic carry_d;
  logic set_en;
  logic clr_en;

  assign set_en = (state_i == WS_GRAB);
  assign clr_en = (state_i == WS_EJECT) || (state_i == WS_INIT);

  always_comb begin
    carry_d = carry_q;
    if (clr_en)      carry_d = 1'b0;
    else if (set_en) carry_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  assign carrying_o = carry_q;

  // R6
  grab_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == WS_GRAB) |=> carrying_o);

  // R10
  eject_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == WS_EJECT) |=> !carrying_o);

endmodule

// File: rtl/mw_action_decode.sv
module mw_action_decode
  import maze_walker_pkg::*;
(
  input  walker_state_t    state_i,
  output logic [N_ACT-1:0] act_o
);

  always_comb begin
    act_o = '0;
    case (state_i)
      WS_FWD:              act_o[ACT_FWD]   = 1'b1;
      WS_TURN_L:           act_o[ACT_CCW]   = 1'b1;
      WS_TURN_R,
      WS_SPIN_A,
      WS_SPIN_B:           act_o[ACT_CW]    = 1'b1;
      WS_GRAB:             act_o[ACT_PICK]  = 1'b1;
      WS_EJECT:            act_o[ACT_THROW] = 1'b1;
      WS_JUMP, WS_HALT:    act_o[ACT_SHUT]  = 1'b1;
      default:             act_o = '0;
    endcase
  end

endmodule

// File: rtl/maze_walker.sv
module maze_walker
  import maze_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DIR-1:0] wall_i,
  input  logic [N_DIR-1:0] light_i,
  input  logic             batt_low_i,
  input  logic             gem_here_i,
  input  logic             hatch_i,
  output logic [N_ACT-1:0] act_o,
  output logic             carrying_o
);

  walker_state_t state;
  logic          carrying;

  mw_sequencer u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wall_i     (wall_i),
    .light_i    (light_i),
    .batt_low_i (batt_low_i),
    .gem_here_i (gem_here_i),
    .hatch_i    (hatch_i),
    .carrying_i (carrying),
    .state_o    (state)
  );

  mw_carry_flag u_carry (
    .clk        (clk),
    .rst_n      (rst_n),
    .state_i    (state),
    .carrying_o (carrying)
  );

  mw_action_decode u_dec (
    .state_i (state),
    .act_o   (act_o)
  );

  assign carrying_o = carrying;

  // R2
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_o) && !act_o[ACT_BACK]);

  // R11
  shut_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o[ACT_SHUT] |=> act_o[ACT_SHUT]);

endmodule

// File: tb/maze_walker_bench.sv
module maze_walker_bench;

  localparam int CLK_PERIOD = 10;
  localparam int QTR = CLK_PERIOD / 4;

  localparam int M_INIT = 0, M_SEEK = 1, M_FWD = 2, M_TL = 3, M_TR = 4,
                 M_SPA = 5, M_SPB = 6, M_GRAB = 7, M_EJECT = 8, M_JUMP = 9,
                 M_HALT = 10;

  logic       clk;
  logic       rst_n;
  logic [3:0] wall;
  logic [3:0] light;
  logic       batt;
  logic       gem;
  logic       hatch;
  logic [6:0] act;
  logic       carrying;

  int n_checks = 0;
  int n_fails  = 0;
  int m_st;
  bit m_carry;

  maze_walker u_maze_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .wall_i     (wall),
    .light_i    (light),
    .batt_low_i (batt),
    .gem_here_i (gem),
    .hatch_i    (hatch),
    .act_o      (act),
    .carrying_o (carrying)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int m_next(int s, logic [3:0] w, logic [3:0] l,
                                bit b, bit g, bit h, bit c);
    bit ex;
    ex = (b || c) && (l != 4'd0);
    case (s)
      M_INIT: return M_SEEK;
      M_SEEK: begin
        if (b && h)          return M_JUMP;
        if (c && h)          return M_EJECT;
        if (ex && l[0])      return M_TL;
        if (ex && l[1])      return M_FWD;
        if (ex && l[2])      return M_TR;
        if (ex && l[3])      return M_SPA;
        if (!c && g)         return M_GRAB;
        if (!w[0])           return M_TL;
        if (!w[1])           return M_FWD;
        if (!w[2])           return M_TR;
        if (!w[3])           return M_SPA;
        return M_SEEK;
      end
      M_FWD, M_SPB, M_GRAB, M_EJECT: return M_SEEK;
      M_TL, M_TR: return M_FWD;
      M_SPA: return M_SPB;
      default: return M_HALT;
    endcase
  endfunction

  function automatic logic [6:0] act_of(int s);
    case (s)
      M_FWD:               return 7'b0000001;
      M_TL:                return 7'b0001000;
      M_TR, M_SPA, M_SPB:  return 7'b0000100;
      M_GRAB:              return 7'b0010000;
      M_EJECT:             return 7'b0100000;
      M_JUMP, M_HALT:      return 7'b1000000;
      default:             return 7'b0000000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      M_INIT:        return "R1";
      M_SEEK:        return "R12";
      M_FWD:         return "R7";
      M_TL, M_TR:    return "R8";
      M_SPA, M_SPB:  return "R9";
      M_GRAB:        return "R6";
      M_EJECT:       return "R4";
      M_JUMP:        return "R3";
      default:       return "R11";
    endcase
  endfunction

  task automatic check_outputs(string atag, string ctag);
    n_checks++;
    if (act !== act_of(m_st)) begin
      n_fails++;
      $display("FAIL %s act_o actual=%b expected=%b", atag, act, act_of(m_st));
    end
    n_checks++;
    if (carrying !== m_carry) begin
      n_fails++;
      $display("FAIL %s carrying_o actual=%b expected=%b", ctag, carrying, m_carry);
    end
    n_checks++;
    if (!$onehot0(act) || act[1] !== 1'b0) begin
      n_fails++;
      $display("FAIL R2 act_o actual=%b expected=one-hot-or-zero with bit1 low", act);
    end
  endtask

  task automatic step(logic [3:0] w, logic [3:0] l, bit b, bit g, bit h, string tag);
    int prev;
    string ct;
    wall = w; light = l; batt = b; gem = g; hatch = h;
    @(posedge clk);
    prev    = m_st;
    m_st    = m_next(m_st, w, l, b, g, h, m_carry);
    if (prev == M_GRAB) m_carry = 1'b1;
    else if (prev == M_EJECT || prev == M_INIT) m_carry = 1'b0;
    #(QTR);
    ct = (prev == M_GRAB) ? "R6" : (prev == M_EJECT) ? "R10" : ((tag == "") ? "R1" : tag);
    check_outputs((tag == "") ? tag_of(m_st) : tag, ct);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    wall = 4'hF; light = 4'h0; batt = 1'b0; gem = 1'b0; hatch = 1'b0;
    m_st = M_INIT;
    m_carry = 1'b0;
    #(QTR);
    check_outputs("R1", "R1");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #(QTR);
    check_outputs("R1", "R1");
  endtask

  task automatic rand_step();
    int r;
    logic [3:0] l;
    r = $urandom_range(0, 5);
    l = (r < 4) ? 4'(1 << r) : 4'h0;
    step(4'($urandom_range(0, 15)), l, ($urandom_range(0, 9) == 0),
         ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0), "");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog R1 actual=still-running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    apply_reset();

    step(4'hF, 4'h0, 0, 0, 0, "R1");   // INIT -> search
    step(4'hF, 4'h0, 0, 0, 0, "R12");  // boxed in: idle
    step(4'hF, 4'h0, 0, 0, 0, "R12");
    // R7 left-wall order
    step(4'hE, 4'h0, 0, 0, 0, "R7");   // left open -> turn left
    step(4'hF, 4'h0, 0, 0, 0, "R8");   // forward after left turn
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'h0, 4'h0, 0, 0, 0, "R7");   // all open: left still wins
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hD, 4'h0, 0, 0, 0, "R7");   // ahead open
    step(4'hF, 4'h0, 0, 0, 0, "R7");
    step(4'hB, 4'h0, 0, 0, 0, "R7");   // right open
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'h7, 4'h0, 0, 0, 0, "R9");   // only behind open
    step(4'hF, 4'h0, 0, 0, 0, "R9");
    step(4'hF, 4'h0, 0, 0, 0, "R9");
    // R5 light ignored without exit request
    step(4'hF, 4'h1, 0, 0, 0, "R5");
    // R6 pickup
    step(4'hF, 4'h0, 0, 1, 0, "R6");
    step(4'hF, 4'h0, 0, 0, 0, "R6");
    step(4'hF, 4'h0, 0, 1, 0, "R6");   // gem ignored while carrying
    // R5 steering while carrying, outranking gem and walls
    step(4'h0, 4'h1, 0, 1, 0, "R5");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'h0, 4'h2, 0, 0, 0, "R5");
    step(4'hF, 4'h0, 0, 0, 0, "R5");
    step(4'h0, 4'h4, 0, 0, 0, "R5");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'h0, 4'h8, 0, 0, 0, "R5");
    step(4'hF, 4'h0, 0, 0, 0, "R9");
    step(4'hF, 4'h0, 0, 0, 0, "R9");
    // R4 eject outranks light, then R10
    step(4'h0, 4'h1, 0, 0, 1, "R4");
    step(4'hF, 4'h0, 0, 0, 0, "R10");
    // R5 steering from low battery alone
    step(4'hF, 4'h1, 1, 0, 0, "R5");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    step(4'hF, 4'h0, 0, 0, 0, "R8");
    // carry again, then battery low + carrying + hatch: jump wins
    step(4'hF, 4'h0, 0, 1, 0, "R6");
    step(4'hF, 4'h0, 0, 0, 0, "R6");
    step(4'h0, 4'h1, 1, 1, 1, "R3");
    for (int i = 0; i < 6; i++) begin
      step(4'($urandom_range(0, 15)), 4'h2, 0, 1, 0, "R11");
    end

    // random blocks, each started from reset
    for (int blk = 0; blk < 30; blk++) begin
      @(posedge clk);
      #(QTR);
      apply_reset();
      for (int k = 0; k < 40; k++) rand_step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule